// File: doc/BRIEF.md
# Home Directory Slice with Migrated-Entry Redirect

This block is the coherence directory slice that one node of a 16-core mesh keeps for the line addresses homed on it. For every tracked line it stores a 16-bit presence vector of caching cores, an owner core and a dirty flag. It serves four kinds of incoming message: read, write, replacement notice and update-home. It answers by forwarding reads, invalidating sharers, fetching missing entries from the upper level, asking memory for a writeback, and finally responding to the requester.

A line that a core has taken over as producer leaves this slice. A small redirect table then records which core now holds its directory entry. A read or write that misses the local directory but hits the redirect table is sent straight to that core as a producer request. The redirect table changes only on explicit update-home messages. The slice serves one transaction at a time. While a transaction is open the request port is held not-ready, so waiting requests are taken in arrival order.

Top module: `dirmh_home`

## Requirements
- R1: After reset, `req_ready` is 1 and none of `fwd_valid`, `inv_valid`, `dreq_valid`, `fetch_valid`, `wb_valid`, `rsp_valid` is asserted.
- R2: A read (`req_op`=0) that hits the directory produces one `fwd_valid` pulse. If sharers exist, the pulse goes to the lowest-numbered sharer with `fwd_mem`=0; otherwise it has `fwd_mem`=1. `fwd_req` carries the requester.
- R3: When `data_in_valid` arrives for a forwarded read, `rsp_valid` pulses to the requester with `rsp_excl`=0. `rsp_sharers` is the old presence vector with the requester's bit set.
- R4: A write (`req_op`=1) that hits the directory with other sharers pulses `inv_valid`. The mask is the presence vector with the requester's bit cleared. `dreq_valid` is pulsed in the same cycle to the lowest-numbered core of that mask.
- R5: After R4, the response waits for exactly popcount(mask) `ack_valid` pulses. It arrives on the last one as `rsp_valid` with `rsp_excl`=1, `rsp_dst` the requester and `rsp_sharers` the requester's one-hot bit.
- R6: While a transaction is open, `req_ready` is 0. A request held valid during that time is accepted after the response and takes effect after it. At most one of the fwd, inv, fetch, wb and rsp pulses is high in any cycle.
- R7: A read or write that misses the directory but hits the redirect table produces `fwd_valid` with `fwd_prod`=1 and `fwd_dst` set to the recorded core. No fetch is issued.
- R8: A read or write that misses both tables pulses `fetch_valid` with `msg_addr` set to the line. After `fetch_done`, the returned vector, owner and dirty flag are installed, and the request proceeds as a directory hit.
- R9: An update-home (`req_op`=3) from core N points the line's redirect entry at N, overwriting any earlier core.
- R10: A replacement notice (`req_op`=2) clears the sender's bit in the presence vector. If the sender is the owner and the line is dirty, `wb_valid` pulses with `msg_addr` and the dirty flag clears; otherwise no writeback is issued.
- R11: A completed write hands the entry to the writer and removes it from the directory. A later read of the line is redirected (R7) if an update-home came in, and fetched (R8) otherwise.
- R12: A write that hits with no sharer other than the requester forwards to memory (`fwd_mem`=1). It responds with `rsp_excl`=1 when the data returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Slice can accept a request |
| req_op | input | 2 | 0 read, 1 write, 2 replacement notice, 3 update-home |
| req_src | input | 4 | Sending core |
| req_addr | input | ADDR_W | Line address |
| ack_valid | input | 1 | One invalidate acknowledgement |
| data_in_valid | input | 1 | Data returned for a forwarded request |
| fetch_done | input | 1 | Upper-level entry fetch complete |
| fetch_sharers | input | 16 | Fetched presence vector |
| fetch_owner | input | 4 | Fetched owner core |
| fetch_dirty | input | 1 | Fetched dirty flag |
| fwd_valid | output | 1 | Forward pulse |
| fwd_dst | output | 4 | Forward target core |
| fwd_prod | output | 1 | Forward is a producer request to the new home |
| fwd_mem | output | 1 | Forward goes to memory |
| fwd_req | output | 4 | Original requester of the forward |
| inv_valid | output | 1 | Invalidate pulse |
| inv_mask | output | 16 | Cores to invalidate |
| dreq_valid | output | 1 | Data request pulse |
| dreq_dst | output | 4 | Core asked for data |
| fetch_valid | output | 1 | Upper-level entry fetch request |
| wb_valid | output | 1 | Writeback-to-memory request |
| msg_addr | output | ADDR_W | Line address of the current outgoing message |
| rsp_valid | output | 1 | Response pulse |
| rsp_dst | output | 4 | Response target |
| rsp_excl | output | 1 | Response grants exclusive ownership and the entry |
| rsp_sharers | output | 16 | Presence vector carried with the response |

## Verification
Two things can meet in one cycle: the final acknowledgement that retires a write, which also drops the entry, and a request that has been stalled behind that write. The bench holds an update-home for the same line valid across the whole acknowledgement phase. It checks that the port stays closed until the response cycle, and that the response and the reopened port arrive together. A read of the line after that must go to the new producer, not to a stale local entry. Random runs vary the presence vectors and writers, so that empty, single and many-sharer masks all reach the invalidate and forward paths.

// File: rtl/dirmh_pkg.sv
package dirmh_pkg;
  localparam int unsigned NCORE  = 16;
  localparam int unsigned NODE_W = $clog2(NCORE);
  localparam int unsigned CNT_W  = $clog2(NCORE + 1);

  typedef logic [NCORE-1:0]  vec_t;
  typedef logic [NODE_W-1:0] node_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic [1:0] {
    OP_RD = 2'd0,
    OP_WR = 2'd1,
    OP_WB = 2'd2,
    OP_UH = 2'd3
  } op_e;

  typedef struct packed {
    vec_t  sharers;
    node_t owner;
    logic  dirty;
  } dir_st_t;

  function automatic cnt_t vec_pop(input vec_t v);
    cnt_t c = '0;
    for (int i = 0; i < NCORE; i++) c = c + cnt_t'(v[i]);
    return c;
  endfunction

  function automatic node_t vec_low(input vec_t v);
    node_t r = '0;
    for (int i = NCORE - 1; i >= 0; i--) if (v[i]) r = node_t'(i);
    return r;
  endfunction

  function automatic vec_t node_bit(input node_t n);
    return vec_t'(1) << n;
  endfunction
endpackage

// File: rtl/dirmh_dir_table.sv
module dirmh_dir_table
  import dirmh_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output dir_st_t           lk_st,
  input  logic              upd_en,
  input  logic              upd_keep,
  input  dir_st_t           upd_st,
  input  logic              ins_en,
  input  dir_st_t           ins_st
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              valid_q [DEPTH];
  logic [ADDR_W-1:0] tag_q   [DEPTH];
  dir_st_t           st_q    [DEPTH];
  logic [DEPTH-1:0]  hit_vec;
  logic [IW-1:0]     hit_idx, vic_idx, rr_q;
  logic              has_free;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_addr);
  end

  always_comb begin
    hit_idx  = '0;
    lk_st    = '0;
    vic_idx  = rr_q;
    has_free = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) begin
        hit_idx = IW'(i);
        lk_st   = st_q[i];
      end
      if (!valid_q[i] && !has_free) begin
        vic_idx  = IW'(i);
        has_free = 1'b1;
      end
    end
  end
  assign lk_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
      for (int i = 0; i < DEPTH; i++) valid_q[i] <= 1'b0;
    end else if (ins_en) begin
      valid_q[vic_idx] <= 1'b1;
      tag_q[vic_idx]   <= lk_addr;
      st_q[vic_idx]    <= ins_st;
      if (!has_free) rr_q <= (rr_q == IW'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
    end else if (upd_en && lk_hit) begin
      valid_q[hit_idx] <= upd_keep;
      st_q[hit_idx]    <= upd_st;
    end
  end

  assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  assert_install_hits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ins_en) && $stable(lk_addr)) |-> lk_hit);
endmodule

// File: rtl/dirmh_nh_table.sv
module dirmh_nh_table
  import dirmh_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output node_t             lk_core,
  input  logic              set_en,
  input  node_t             set_core
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              valid_q [DEPTH];
  logic [ADDR_W-1:0] tag_q   [DEPTH];
  node_t             core_q  [DEPTH];
  logic [DEPTH-1:0]  hit_vec;
  logic [IW-1:0]     hit_idx, vic_idx, rr_q;
  logic              has_free;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_addr);
  end

  always_comb begin
    hit_idx  = '0;
    lk_core  = '0;
    vic_idx  = rr_q;
    has_free = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) begin
        hit_idx = IW'(i);
        lk_core = core_q[i];
      end
      if (!valid_q[i] && !has_free) begin
        vic_idx  = IW'(i);
        has_free = 1'b1;
      end
    end
  end
  assign lk_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
      for (int i = 0; i < DEPTH; i++) valid_q[i] <= 1'b0;
    end else if (set_en) begin
      if (lk_hit) begin
        core_q[hit_idx] <= set_core;
      end else begin
        valid_q[vic_idx] <= 1'b1;
        tag_q[vic_idx]   <= lk_addr;
        core_q[vic_idx]  <= set_core;
        if (!has_free) rr_q <= (rr_q == IW'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  assert_latest_home_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set_en) && $stable(lk_addr)) |-> (lk_hit && lk_core == $past(set_core)));
endmodule

// File: rtl/dirmh_home.sv
module dirmh_home
  import dirmh_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DIR_DEPTH = 8,
  parameter int unsigned NH_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [3:0]        req_src,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              ack_valid,
  input  logic              data_in_valid,
  input  logic              fetch_done,
  input  logic [15:0]       fetch_sharers,
  input  logic [3:0]        fetch_owner,
  input  logic              fetch_dirty,
  output logic              fwd_valid,
  output logic [3:0]        fwd_dst,
  output logic              fwd_prod,
  output logic              fwd_mem,
  output logic [3:0]        fwd_req,
  output logic              inv_valid,
  output logic [15:0]       inv_mask,
  output logic              dreq_valid,
  output logic [3:0]        dreq_dst,
  output logic              fetch_valid,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] msg_addr,
  output logic              rsp_valid,
  output logic [3:0]        rsp_dst,
  output logic              rsp_excl,
  output logic [15:0]       rsp_sharers
);
  typedef enum logic [2:0] {S_IDLE, S_DECIDE, S_FETCH, S_WDATA, S_WACK} state_e;

  state_e            state;
  op_e               cur_op;
  node_t             cur_src;
  logic [ADDR_W-1:0] cur_addr;
  cnt_t              ack_cnt;

  logic    dir_hit, nh_hit;
  dir_st_t dir_st, upd_st, ins_st;
  node_t   nh_core;
  logic    upd_en, upd_keep, ins_en, nh_set;

  // named internal events
  vec_t src_bit, others;
  logic wb_fire, last_ack;
  assign src_bit  = node_bit(cur_src);
  assign others   = dir_st.sharers & ~src_bit;
  assign wb_fire  = dir_hit && dir_st.dirty && (dir_st.owner == cur_src);
  assign last_ack = (state == S_WACK) && ack_valid && (ack_cnt == cnt_t'(1));

  assign req_ready = (state == S_IDLE);
  assign msg_addr  = cur_addr;
  assign ins_st    = '{sharers: fetch_sharers, owner: fetch_owner, dirty: fetch_dirty};

  dirmh_dir_table #(.DEPTH(DIR_DEPTH), .ADDR_W(ADDR_W)) u_dir (
    .clk(clk), .rst_n(rst_n), .lk_addr(cur_addr), .lk_hit(dir_hit), .lk_st(dir_st),
    .upd_en(upd_en), .upd_keep(upd_keep), .upd_st(upd_st),
    .ins_en(ins_en), .ins_st(ins_st));

  dirmh_nh_table #(.DEPTH(NH_DEPTH), .ADDR_W(ADDR_W)) u_nh (
    .clk(clk), .rst_n(rst_n), .lk_addr(cur_addr), .lk_hit(nh_hit), .lk_core(nh_core),
    .set_en(nh_set), .set_core(cur_src));

  // table write control
  always_comb begin
    upd_en   = 1'b0;
    upd_keep = 1'b1;
    upd_st   = dir_st;
    ins_en   = 1'b0;
    nh_set   = 1'b0;
    unique case (state)
      S_DECIDE: begin
        if (cur_op == OP_UH) nh_set = 1'b1;
        if (cur_op == OP_WB && dir_hit) begin
          upd_en         = 1'b1;
          upd_st.sharers = dir_st.sharers & ~src_bit;
          if (wb_fire) upd_st.dirty = 1'b0;
        end
      end
      S_FETCH: ins_en = fetch_done;
      S_WDATA: if (data_in_valid) begin
        upd_en = 1'b1;
        if (cur_op == OP_RD) upd_st.sharers = dir_st.sharers | src_bit;
        else                 upd_keep = 1'b0;
      end
      S_WACK: if (last_ack) begin
        upd_en   = 1'b1;
        upd_keep = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cur_op      <= OP_RD;
      cur_src     <= '0;
      cur_addr    <= '0;
      ack_cnt     <= '0;
      fwd_valid   <= 1'b0; fwd_dst <= '0; fwd_prod <= 1'b0; fwd_mem <= 1'b0; fwd_req <= '0;
      inv_valid   <= 1'b0; inv_mask <= '0;
      dreq_valid  <= 1'b0; dreq_dst <= '0;
      fetch_valid <= 1'b0; wb_valid <= 1'b0;
      rsp_valid   <= 1'b0; rsp_dst <= '0; rsp_excl <= 1'b0; rsp_sharers <= '0;
    end else begin
      fwd_valid   <= 1'b0;
      inv_valid   <= 1'b0;
      dreq_valid  <= 1'b0;
      fetch_valid <= 1'b0;
      wb_valid    <= 1'b0;
      rsp_valid   <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          cur_op   <= op_e'(req_op);
          cur_src  <= req_src;
          cur_addr <= req_addr;
          state    <= S_DECIDE;
        end
        S_DECIDE: begin
          state   <= S_IDLE;
          fwd_req <= cur_src;
          if (cur_op == OP_WB) begin
            wb_valid <= wb_fire;
          end else if (cur_op != OP_UH) begin
            if (dir_hit) begin
              if (cur_op == OP_WR && others != '0) begin
                inv_valid  <= 1'b1;
                inv_mask   <= others;
                dreq_valid <= 1'b1;
                dreq_dst   <= vec_low(others);
                ack_cnt    <= vec_pop(others);
                state      <= S_WACK;
              end else begin
                fwd_valid <= 1'b1;
                fwd_prod  <= 1'b0;
                fwd_mem   <= (cur_op == OP_WR) || (dir_st.sharers == '0);
                fwd_dst   <= vec_low(dir_st.sharers);
                state     <= S_WDATA;
              end
            end else if (nh_hit) begin
              fwd_valid <= 1'b1;
              fwd_prod  <= 1'b1;
              fwd_mem   <= 1'b0;
              fwd_dst   <= nh_core;
            end else begin
              fetch_valid <= 1'b1;
              state       <= S_FETCH;
            end
          end
        end
        S_FETCH: if (fetch_done) state <= S_DECIDE;
        S_WDATA: if (data_in_valid) begin
          rsp_valid   <= 1'b1;
          rsp_dst     <= cur_src;
          rsp_excl    <= (cur_op == OP_WR);
          rsp_sharers <= (cur_op == OP_WR) ? src_bit : (dir_st.sharers | src_bit);
          state       <= S_IDLE;
        end
        S_WACK: if (ack_valid) begin
          ack_cnt <= ack_cnt - 1'b1;
          if (last_ack) begin
            rsp_valid   <= 1'b1;
            rsp_dst     <= cur_src;
            rsp_excl    <= 1'b1;
            rsp_sharers <= src_bit;
            state       <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_no_self_inval_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !inv_mask[cur_src]);
  assert_dreq_in_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (dreq_valid && inv_mask[dreq_dst]));
  assert_ack_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WACK) |-> (ack_cnt != '0));
  assert_one_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, inv_valid, fetch_valid, rsp_valid, wb_valid}));
  assert_fwd_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !(fwd_prod && fwd_mem));
  assert_wb_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(cur_op == OP_WB));
endmodule

// File: tb/dirmh_home_tb.sv
`timescale 1ns/1ps
module dirmh_home_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, ack_valid = 0, data_in_valid = 0, fetch_done = 0, fetch_dirty = 0;
  logic [1:0] req_op = 0;
  logic [3:0] req_src = 0, fetch_owner = 0;
  logic [7:0] req_addr = 0;
  logic [15:0] fetch_sharers = 0;
  logic req_ready, fwd_valid, fwd_prod, fwd_mem, inv_valid, dreq_valid, fetch_valid, wb_valid;
  logic rsp_valid, rsp_excl;
  logic [3:0] fwd_dst, fwd_req, dreq_dst, rsp_dst;
  logic [15:0] inv_mask, rsp_sharers;
  logic [7:0] msg_addr;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dirmh_home u_dut (.*);

  function automatic logic [3:0] ref_low(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 4'(i);
    return 4'd0;
  endfunction
  function automatic int ref_pop(input logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) if (v[i]) c++;
    return c;
  endfunction
  function automatic logic [15:0] ref_bit(input logic [3:0] n);
    return 16'h1 << n;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [3:0] src, input logic [7:0] a);
    @(negedge clk);
    req_valid = 1; req_op = op; req_src = src; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    @(posedge clk); @(negedge clk);
  endtask
  task automatic give_fetch(input logic [15:0] sh, input logic [3:0] own, input logic dty);
    @(negedge clk);
    fetch_done = 1; fetch_sharers = sh; fetch_owner = own; fetch_dirty = dty;
    @(posedge clk); @(negedge clk);
    fetch_done = 0;
    @(posedge clk); @(negedge clk);
  endtask
  task automatic give_data();
    @(negedge clk); data_in_valid = 1;
    @(posedge clk); @(negedge clk); data_in_valid = 0;
  endtask
  task automatic give_ack();
    @(negedge clk); ack_valid = 1;
    @(posedge clk); @(negedge clk); ack_valid = 0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
    chk({fwd_valid, inv_valid, dreq_valid, fetch_valid, wb_valid, rsp_valid} === 6'b0,
        "R1 idle pulses", {fwd_valid, inv_valid, dreq_valid, fetch_valid, wb_valid, rsp_valid}, 0);

    // R9 update-home overwrite
    send(2'd3, 4'd5, 8'h30);
    send(2'd3, 4'd9, 8'h30);
    send(2'd0, 4'd2, 8'h30);
    chk(fwd_valid && fwd_prod && fwd_dst == 4'd9, "R9 latest new home", fwd_dst, 9);
    chk(!fetch_valid, "R7 no fetch on redirect", fetch_valid, 0);

    // R10 replacement notices
    send(2'd0, 4'd3, 8'h10);
    give_fetch(16'h0006, 4'd1, 1'b1);
    chk(fwd_valid && !fwd_mem && fwd_dst == 4'd1, "R2 lowest sharer", fwd_dst, 1);
    give_data();
    send(2'd2, 4'd2, 8'h10);
    chk(!wb_valid, "R10 clean non-owner no wb", wb_valid, 0);
    send(2'd2, 4'd1, 8'h10);
    chk(wb_valid && msg_addr == 8'h10, "R10 dirty owner wb", {wb_valid, msg_addr}, 9'h110);
    send(2'd2, 4'd1, 8'h10);
    chk(!wb_valid, "R10 dirty cleared", wb_valid, 0);
    send(2'd1, 4'd3, 8'h10);
    chk(fwd_valid && fwd_mem && !inv_valid, "R12 lone writer to memory", {fwd_mem, inv_valid}, 2'b10);
    give_data();
    chk(rsp_valid && rsp_excl && rsp_dst == 4'd3, "R12 write grant", rsp_dst, 3);

    // R6 held request behind the final acknowledgement
    send(2'd0, 4'd1, 8'h20);
    give_fetch(16'h0030, 4'd4, 1'b0);
    chk(fwd_valid && fwd_dst == 4'd4, "R2 fetched then forwarded", fwd_dst, 4);
    give_data();
    send(2'd1, 4'd7, 8'h20);
    chk(inv_valid && inv_mask == 16'h0032, "R4 mask", inv_mask, 16'h0032);
    @(negedge clk);
    req_valid = 1; req_op = 2'd3; req_src = 4'd7; req_addr = 8'h20;
    give_ack();
    chk(!req_ready && !rsp_valid, "R6 stalled ack1", {req_ready, rsp_valid}, 0);
    give_ack();
    chk(!req_ready && !rsp_valid, "R6 stalled ack2", {req_ready, rsp_valid}, 0);
    give_ack();
    chk(rsp_valid && req_ready, "R6 release with response", {rsp_valid, req_ready}, 2'b11);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    @(posedge clk); @(negedge clk);
    send(2'd0, 4'd4, 8'h20);
    chk(fwd_valid && fwd_prod && fwd_dst == 4'd7, "R11 held update applied after handoff", fwd_dst, 7);

    // random runs
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a;
      logic [3:0] rs, ws;
      logic [15:0] sh, oth;
      int n;
      a  = 8'h40 + 8'(i);
      rs = 4'($urandom % 16);
      ws = 4'($urandom % 16);
      sh = (i % 4 == 0) ? 16'h0 : 16'($urandom);
      send(2'd0, rs, a);
      chk(fetch_valid && msg_addr == a, "R8 fetch on double miss", msg_addr, a);
      give_fetch(sh, 4'($urandom), 1'b0);
      chk(fwd_valid && fwd_mem == (sh == 0) && fwd_req == rs, "R2 forward kind", {fwd_mem, fwd_req}, {(sh == 0), rs});
      if (sh != 0) chk(fwd_dst == ref_low(sh), "R2 forward target", fwd_dst, ref_low(sh));
      give_data();
      chk(rsp_valid && rsp_dst == rs && !rsp_excl && rsp_sharers == (sh | ref_bit(rs)),
          "R3 read response", rsp_sharers, sh | ref_bit(rs));
      sh  = sh | ref_bit(rs);
      oth = sh & ~ref_bit(ws);
      send(2'd1, ws, a);
      if (oth != 0) begin
        chk(inv_valid && inv_mask == oth, "R4 invalidate mask", inv_mask, oth);
        chk(dreq_valid && dreq_dst == ref_low(oth), "R4 data request target", dreq_dst, ref_low(oth));
        n = ref_pop(oth);
        for (int k = 0; k < n; k++) begin
          give_ack();
          if (k < n - 1) chk(!rsp_valid && !req_ready, "R5 waiting for acks", rsp_valid, 0);
          else chk(rsp_valid && rsp_excl && rsp_dst == ws && rsp_sharers == ref_bit(ws),
                   "R5 grant after last ack", rsp_sharers, ref_bit(ws));
        end
      end else begin
        chk(fwd_valid && fwd_mem && !inv_valid, "R12 no other sharers", fwd_mem, 1);
        give_data();
        chk(rsp_valid && rsp_excl && rsp_dst == ws, "R12 grant", rsp_dst, ws);
      end
      if (i % 2 == 1) begin
        send(2'd3, ws, a);
        send(2'd0, rs, a);
        chk(fwd_valid && fwd_prod && fwd_dst == ws, "R7 producer redirect", fwd_dst, ws);
      end else begin
        send(2'd0, rs, a);
        chk(fetch_valid && !fwd_valid, "R11 entry handed off", fetch_valid, 1);
        give_fetch(16'h0, 4'd0, 1'b0);
        chk(fwd_valid && fwd_mem, "R8 refetched no sharers to memory", fwd_mem, 1);
        give_data();
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule